// File: doc/BRIEF.md
# Three-Wire Serial Control Register Slave

This block is a write-only slave on a three-line serial control bus. The lines are a mode line, a bit clock and a data line. All three are oversampled by the faster system clock through a synchronizer. A byte received with the mode line low is an address byte. Its upper six bits are compared against the device address, and its lower two bits set a transfer type. A byte received with the mode line high is a data byte. If the device is currently selected, the byte is routed into one of the control registers.

A register is chosen in two steps. The transfer type latched from the address byte picks a group. Bits 7:6 of each data byte then pick a register within that group. The selection remains in force for any number of data bytes, until another address byte arrives. The register contents drive the outputs directly. These are the system clock ratio, the serial input format, the volume, the de-emphasis choice and the mute flag.

Top module: `ctl3w_slave`

## Requirements
- R1: After reset, every output field is zero and the device is deselected. Zero means 512fs ratio, the I2S format, volume 0, de-emphasis off and mute off.
- R2: A byte is 8 bits, taken MSB first on rising edges of the bit clock. The mode line sets the byte kind: low means address byte, high means data byte.
- R3: An address byte selects the device only when bits 7:2 equal 000101. In the same byte, bits 1:0 set the transfer type: 00 = DATA, 10 = STATUS, 01 and 11 unused.
- R4: An address byte with any other device address deselects the device. Data bytes then leave every output unchanged until a matching address byte arrives.
- R5: The selection and transfer type stay in force over any number of consecutive data bytes.
- R6: A change of the mode line restarts the bit count. A partial byte cut short in this way changes no output.
- R7: For STATUS with selector 00, the clock ratio is taken from bits 5:4 and the format from bits 3:1. Ratio codes are 00 = 512fs, 01 = 384fs, 10 = 256fs. Format codes are 000 = I2S, 001/010/011 = LSB-justified 16/18/20 bits, and 100 = MSB-justified. A byte carrying ratio 11 or a format above 100 is ignored as a whole.
- R8: For DATA with selector 00, the volume is taken from bits 5:0.
- R9: For DATA with selector 01, de-emphasis is taken from bits 4:3 (00 off, 01 32 kHz, 10 44.1 kHz, 11 48 kHz) and mute from bit 2.
- R10: Data bytes are ignored when the transfer type is unused (01 or 11). They are also ignored when the selector is reserved: STATUS selectors 01/10/11 and DATA selectors 10/11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_mode_i | input | 1 | Mode line (low address, high data) |
| ctl_clk_i | input | 1 | Serial bit clock |
| ctl_data_i | input | 1 | Serial data line |
| clk_ratio_o | output | 2 | System clock ratio code |
| in_fmt_o | output | 3 | Serial input format code |
| volume_o | output | 6 | Volume field |
| deemph_o | output | 2 | De-emphasis choice |
| mute_o | output | 1 | Mute flag |

## Verification
The eighth rising edge of the bit clock passes through SYNC_STAGES synchronizer flops and then one edge-detect compare. After that comes one cycle for the byte-complete pulse, and the register is written at the next edge. An output therefore changes at most SYNC_STAGES+2 system clocks after the bit-clock edge. The bench waits ten system clocks after each byte before it compares all five fields against a model built from the requirements, so every check samples settled state. Partial bytes and ignored bytes are checked after the same wait, so any stray write would already be visible.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 6;
   localparam int VOL_W  = 6;
   localparam int FMT_W  = 3;

   typedef enum logic [1:0] {
      XT_DATA   = 2'b00,
      XT_UNUSED1 = 2'b01,
      XT_STATUS = 2'b10,
      XT_UNUSED3 = 2'b11
   } xfer_t;

   typedef enum logic [1:0] {
      CR_512 = 2'b00,
      CR_384 = 2'b01,
      CR_256 = 2'b10,
      CR_RSV = 2'b11
   } clk_ratio_t;

   localparam logic [FMT_W-1:0] FMT_MAX = 3'd4;

   typedef struct packed {
      logic [1:0]       clk_ratio;
      logic [FMT_W-1:0] in_fmt;
      logic [VOL_W-1:0] volume;
      logic [1:0]       deemph;
      logic             mute;
   } ctl_regs_t;
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ctl3w_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("ctl3w_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ctl3w_shifter.sv
module ctl3w_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_s,
   input  logic              sclk_s,
   input  logic              sdata_s,
   output logic              byte_vld,
   output logic              byte_is_addr,
   output logic [BYTE_W-1:0] byte_q
);
   localparam int CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

   if (BYTE_W < 2) begin : g_bad_byte
      $error("ctl3w_shifter: BYTE_W must be at least 2");
   end

   logic              sclk_d;
   logic              mode_d;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] shnext;
   logic              rise;

   assign rise   = sclk_s & ~sclk_d;
   assign shnext = {shreg[BYTE_W-2:0], sdata_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d       <= 1'b0;
         mode_d       <= 1'b0;
         cnt          <= '0;
         shreg        <= '0;
         byte_vld     <= 1'b0;
         byte_is_addr <= 1'b0;
         byte_q       <= '0;
      end else begin
         sclk_d   <= sclk_s;
         mode_d   <= mode_s;
         byte_vld <= 1'b0;
         if (mode_s != mode_d) begin
            cnt <= '0;
         end else if (rise) begin
            shreg <= shnext;
            if (cnt == CNT_LAST) begin
               cnt          <= '0;
               byte_vld     <= 1'b1;
               byte_q       <= shnext;
               byte_is_addr <= ~mode_s;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R2
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |=> !byte_vld);

   // R6
   restart_on_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_s != mode_d) |=> (cnt == '0 && !byte_vld));
endmodule

// File: rtl/ctl3w_regfile.sv
module ctl3w_regfile
   import ctl3w_pkg::*;
#(
   parameter logic [ADDR_W-1:0] DEV_ADDR = 6'b000101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_vld,
   input  logic              byte_is_addr,
   input  logic [BYTE_W-1:0] byte_q,
   output ctl_regs_t         regs
);
   if (BYTE_W != ADDR_W + 2) begin : g_bad_layout
      $error("ctl3w_regfile: address and type must fill one byte");
   end

   logic  sel_q;
   xfer_t type_q;
   logic  data_wr;
   logic [1:0] sub;
   logic       status_ok;

   assign data_wr   = byte_vld && !byte_is_addr && sel_q;
   assign sub       = byte_q[7:6];
   assign status_ok = (byte_q[5:4] != CR_RSV) && (byte_q[3:1] <= FMT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= 1'b0;
         type_q <= XT_DATA;
      end else if (byte_vld && byte_is_addr) begin
         sel_q  <= (byte_q[BYTE_W-1:2] == DEV_ADDR);
         type_q <= xfer_t'(byte_q[1:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regs <= '0;
      end else if (data_wr) begin
         unique case (type_q)
            XT_STATUS: begin
               if (sub == 2'b00 && status_ok) begin
                  regs.clk_ratio <= byte_q[5:4];
                  regs.in_fmt    <= byte_q[3:1];
               end
            end
            XT_DATA: begin
               if (sub == 2'b00) begin
                  regs.volume <= byte_q[5:0];
               end else if (sub == 2'b01) begin
                  regs.deemph <= byte_q[4:3];
                  regs.mute   <= byte_q[2];
               end
            end
            default: ;
         endcase
      end
   end

   // R4
   hold_unless_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(byte_vld && !byte_is_addr && sel_q) |=> $stable(regs));

   // R7
   ratio_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      regs.clk_ratio != CR_RSV);

   // R7
   fmt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      regs.in_fmt <= FMT_MAX);

   // R10
   unused_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && !byte_is_addr && type_q[0]) |=> $stable(regs));
endmodule

// File: rtl/ctl3w_slave.sv
module ctl3w_slave
   import ctl3w_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] DEV_ADDR    = 6'b000101
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_mode_i,
   input  logic       ctl_clk_i,
   input  logic       ctl_data_i,
   output logic [1:0] clk_ratio_o,
   output logic [2:0] in_fmt_o,
   output logic [5:0] volume_o,
   output logic [1:0] deemph_o,
   output logic       mute_o
);
   logic [2:0]        pins_s;
   logic              byte_vld;
   logic              byte_is_addr;
   logic [BYTE_W-1:0] byte_q;
   ctl_regs_t         regs;

   ctl3w_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({ctl_mode_i, ctl_clk_i, ctl_data_i}),
      .q_o   (pins_s)
   );

   ctl3w_shifter #(.BYTE_W(BYTE_W)) u_shift (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_s       (pins_s[2]),
      .sclk_s       (pins_s[1]),
      .sdata_s      (pins_s[0]),
      .byte_vld     (byte_vld),
      .byte_is_addr (byte_is_addr),
      .byte_q       (byte_q)
   );

   ctl3w_regfile #(.DEV_ADDR(DEV_ADDR)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .byte_vld     (byte_vld),
      .byte_is_addr (byte_is_addr),
      .byte_q       (byte_q),
      .regs         (regs)
   );

   assign clk_ratio_o = regs.clk_ratio;
   assign in_fmt_o    = regs.in_fmt;
   assign volume_o    = regs.volume;
   assign deemph_o    = regs.deemph;
   assign mute_o      = regs.mute;
endmodule

// File: tb/ctl3w_slave_test.sv
module ctl3w_slave_test;
   localparam int CLK_PERIOD = 10;
   localparam int HALF_BIT   = 6;
   localparam int SETTLE     = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode = 1'b0, sck = 1'b0, sda = 1'b0;
   logic [1:0] clk_ratio_o;
   logic [2:0] in_fmt_o;
   logic [5:0] volume_o;
   logic [1:0] deemph_o;
   logic       mute_o;

   int tests = 0, fails = 0;
   bit done = 0;

   logic       m_sel = 0;
   logic [1:0] m_type = 0;
   logic [1:0] e_ratio = 0;
   logic [2:0] e_fmt = 0;
   logic [5:0] e_vol = 0;
   logic [1:0] e_de = 0;
   logic       e_mute = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ctl3w_slave uut (
      .clk(clk), .rst_n(rst_n),
      .ctl_mode_i(mode), .ctl_clk_i(sck), .ctl_data_i(sda),
      .clk_ratio_o(clk_ratio_o), .in_fmt_o(in_fmt_o), .volume_o(volume_o),
      .deemph_o(deemph_o), .mute_o(mute_o)
   );

   task automatic check(input string tag);
      logic [13:0] act, exp;
      act = {clk_ratio_o, in_fmt_o, volume_o, deemph_o, mute_o};
      exp = {e_ratio, e_fmt, e_vol, e_de, e_mute};
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic set_mode(input logic m);
      @(negedge clk);
      if (mode != m) begin
         mode = m;
         repeat (4) @(negedge clk);
      end
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda = b[i];
         repeat (HALF_BIT) @(negedge clk);
         sck = 1'b1;
         repeat (HALF_BIT) @(negedge clk);
         sck = 1'b0;
      end
   endtask

   task automatic model(input logic m, input logic [7:0] b);
      if (!m) begin
         m_sel  = (b[7:2] == 6'b000101);
         m_type = b[1:0];
      end else if (m_sel) begin
         if (m_type == 2'b10) begin
            if (b[7:6] == 2'b00 && b[5:4] != 2'b11 && b[3:1] <= 3'd4) begin
               e_ratio = b[5:4];
               e_fmt   = b[3:1];
            end
         end else if (m_type == 2'b00) begin
            if (b[7:6] == 2'b00) e_vol = b[5:0];
            else if (b[7:6] == 2'b01) begin
               e_de   = b[4:3];
               e_mute = b[2];
            end
         end
      end
   endtask

   task automatic xfer(input logic m, input logic [7:0] b, input string tag);
      set_mode(m);
      send_bits(b, 8);
      model(m, b);
      repeat (SETTLE) @(negedge clk);
      check(tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset state");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 after reset release");

      // R4: deselected after reset, data ignored
      xfer(1'b1, 8'h3F, "R4 data while deselected");

      // R7 / R10: status sweep over ratio x format, selector 00
      xfer(1'b0, {6'b000101, 2'b10}, "R3 select STATUS");
      for (int r = 0; r < 4; r++)
         for (int f = 0; f < 8; f++)
            xfer(1'b1, {2'b00, r[1:0], f[2:0], 1'b0}, "R7 status field");
      for (int s = 1; s < 4; s++)
         xfer(1'b1, {s[1:0], 6'b011010}, "R10 status reserved selector");

      // R8 / R5: full volume sweep under one address
      xfer(1'b0, {6'b000101, 2'b00}, "R3 select DATA");
      for (int v = 0; v < 64; v++)
         xfer(1'b1, {2'b00, v[5:0]}, "R8 R5 volume");
      // R9: de-emphasis and mute sweep
      for (int v = 0; v < 64; v++)
         xfer(1'b1, {2'b01, v[5:0]}, "R9 deemph mute");
      xfer(1'b1, 8'h95, "R10 data selector 10");
      xfer(1'b1, 8'hEA, "R10 data selector 11");

      // R10: unused transfer types
      xfer(1'b0, {6'b000101, 2'b01}, "R3 select type 01");
      xfer(1'b1, 8'h11, "R10 type 01 ignored");
      xfer(1'b0, {6'b000101, 2'b11}, "R3 select type 11");
      xfer(1'b1, 8'h07, "R10 type 11 ignored");

      // R3 / R4: address sweep
      for (int a = 0; a < 64; a++) begin
         xfer(1'b0, {a[5:0], 2'b00}, "R3 address byte");
         xfer(1'b1, {2'b00, a[5:0] ^ 6'h2A}, "R4 data after address");
      end

      // R6: partial byte then mode change
      xfer(1'b0, {6'b000101, 2'b00}, "R3 reselect DATA");
      set_mode(1'b1);
      send_bits(8'h3F, 5);
      repeat (SETTLE) @(negedge clk);
      check("R6 partial byte no effect");
      set_mode(1'b0);
      set_mode(1'b1);
      xfer(1'b1, 8'h05, "R6 full byte after restart");
      xfer(1'b1, 8'h0C, "R2 second byte same mode");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule